// File: doc/BRIEF.md
# Single-Wire Gauge Bus Master

This block is a memory-mapped master for a single-wire, open-drain bus of the kind used by battery fuel gauges. Software loads a byte into the transmit register and writes the control register with the start bit set. The block then does one of three things on the shared data line: it sends the byte, it receives a byte from the slave, or it issues a break (initialisation) pulse. Completion and the receive timeout are reported through sticky flags that clear when read, and through an interrupt output that can be masked.

All bus timing is counted in ticks from a clock prescaler, so the same logic serves any system clock. Bits travel least significant first. A '1' is a short low pulse and a '0' is a long low pulse inside a fixed bit slot. A soft reset, started from the configuration register, returns the block to its reset state and reports when it has finished.

Top module: `sgm_master`

## Requirements
- R1: After reset the control register (offset 0x0C) and the flag register (offset 0x10) read 0x00, the irq output is 0, the line is released, and offset 0x00 reads the version with the major number in bits 7:4 and the minor number in bits 3:0 (0x12 by default).
- R2: Writing 0x0C with bit 4 (start) = 1 and bit 1 (direction) = 0 sends the byte held at offset 0x04, least significant bit first. Each bit slot lasts SLOT_T ticks and begins with a low pulse of ONE_T ticks for a '1' or ZERO_T ticks for a '0'. At the end, flag bit 2 (sent) of 0x10 is set and the start bit reads 0.
- R3: Writing start with direction = 1 receives a byte. Each bit is sampled SAMP_T ticks after the slave's falling edge (line high = 1), least significant bit first. The byte appears at offset 0x08, flag bit 1 (received) is set and start returns to 0.
- R4: Writing start together with bit 2 (break) drives the line low for BRK_T ticks and then releases it for REC_T ticks. Flag bit 0 (timeout) is then set, and the break and start bits both read 0.
- R5: During a receive, if no falling edge arrives within WAIT_T ticks, flag bit 0 is set, the operation ends and start reads 0.
- R6: A read of offset 0x10 returns the three flags and clears them. A flag raised in the same cycle as that read stays set.
- R7: irq goes to 1 one cycle after any flag is set while control bit 6 (interrupt enable) is 1. It stays 0 while the enable bit is 0.
- R8: While start is 1, writes to offset 0x04 and to the start, break and direction bits are ignored. The other control bits can still be written.
- R9: The line is driven low only while start is 1. While control bit 5 (clock enable) is 0, nothing happens on the line. A pending start then waits, and the operation runs once the enable is set.
- R10: Writing 1 to bit 1 of offset 0x14 starts a soft reset. Bit 0 of offset 0x18 (reset done) reads 0 for SRST_CYC cycles and then 1, and all registers return to their reset values. Bit 0 of 0x14 (auto-idle) is stored and reads back; bit 1 reads 0.
- R11: A read strobe returns the addressed register on rd_data in the next cycle, and rd_data keeps that value until the next read. The control register reads back the bits as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| line_in | input | 1 | Sampled level of the shared data line |
| line_drive_low | output | 1 | 1 pulls the open-drain line low |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. The line stays released whenever no operation is in progress. The start bit holds until the engine reports completion. At most one completion event occurs at a time, and only while start is set. A read of the flag register leaves the flags clear. Locked writes leave the transmit byte unchanged. An interrupt needs the enable bit, and a soft reset drops the reset-done indication. Other behaviour can only be shown by the bench scenarios, which a scoreboard compares against the queued expected bytes and breaks. These cover the actual pulse widths and bit order on the line, the received bytes returned from a modelled slave, the receive timeout window, the pending start held by a cleared clock enable, and the registers returning to their reset values after a soft reset.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  localparam int OFF_VER  = 'h00;
  localparam int OFF_TXD  = 'h04;
  localparam int OFF_RXD  = 'h08;
  localparam int OFF_CTRL = 'h0C;
  localparam int OFF_FLAG = 'h10;
  localparam int OFF_CFG  = 'h14;
  localparam int OFF_STAT = 'h18;

  localparam int B_IEN   = 6;
  localparam int B_CLKEN = 5;
  localparam int B_GO    = 4;
  localparam int B_BRK   = 2;
  localparam int B_DIR   = 1;
  localparam int B_MODE  = 0;

  typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} op_kind_e;
endpackage

// File: rtl/sgm_tick.sv
module sgm_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sgm_phy.sv
module sgm_phy
  import sgm_pkg::*;
#(
  parameter int SLOT_T = 190,
  parameter int ONE_T  = 32,
  parameter int ZERO_T = 100,
  parameter int BRK_T  = 190,
  parameter int REC_T  = 40,
  parameter int SAMP_T = 65,
  parameter int WAIT_T = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  op_kind_e   kind,
  input  logic [7:0] tx_byte,
  input  logic       line_in,
  output logic       drv,
  output logic       txd,
  output logic       rxd,
  output logic       tmo,
  output logic [7:0] rx_byte
);
  localparam int M1   = (SLOT_T > BRK_T) ? SLOT_T : BRK_T;
  localparam int M2   = (M1 > WAIT_T) ? M1 : WAIT_T;
  localparam int MAXT = (M2 > REC_T) ? M2 : REC_T;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_TXL, S_TXH, S_BKL, S_BKH, S_RXW, S_RXS} st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          ls1, ls2, lprev;
  logic          fall;

  assign fall = lprev & ~ls2;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      lim     <= '0;
      bitn    <= '0;
      sh      <= '0;
      drv     <= 1'b0;
      txd     <= 1'b0;
      rxd     <= 1'b0;
      tmo     <= 1'b0;
      rx_byte <= '0;
      ls1     <= 1'b1;
      ls2     <= 1'b1;
      lprev   <= 1'b1;
    end else begin
      ls1   <= line_in;
      ls2   <= ls1;
      lprev <= ls2;
      txd   <= 1'b0;
      rxd   <= 1'b0;
      tmo   <= 1'b0;
      case (st)
        S_IDLE: begin
          drv  <= 1'b0;
          cnt  <= '0;
          bitn <= '0;
          if (start) begin
            case (kind)
              OP_TX: begin
                sh  <= tx_byte;
                lim <= tx_byte[0] ? CW'(ONE_T) : CW'(ZERO_T);
                drv <= 1'b1;
                st  <= S_TXL;
              end
              OP_BRK: begin
                drv <= 1'b1;
                st  <= S_BKL;
              end
              default: st <= S_RXW;
            endcase
          end
        end
        S_TXL: if (tick) begin
          if (cnt == lim - CW'(1)) begin
            cnt <= '0;
            drv <= 1'b0;
            st  <= S_TXH;
          end else cnt <= cnt + 1'b1;
        end
        S_TXH: if (tick) begin
          if (cnt == CW'(SLOT_T) - lim - CW'(1)) begin
            cnt <= '0;
            if (bitn == 3'd7) begin
              txd <= 1'b1;
              st  <= S_IDLE;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= sh >> 1;
              lim  <= sh[1] ? CW'(ONE_T) : CW'(ZERO_T);
              drv  <= 1'b1;
              st   <= S_TXL;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_BKL: if (tick) begin
          if (cnt == CW'(BRK_T - 1)) begin
            cnt <= '0;
            drv <= 1'b0;
            st  <= S_BKH;
          end else cnt <= cnt + 1'b1;
        end
        S_BKH: if (tick) begin
          if (cnt == CW'(REC_T - 1)) begin
            tmo <= 1'b1;
            st  <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_RXW: begin
          if (fall) begin
            cnt <= '0;
            st  <= S_RXS;
          end else if (tick) begin
            if (cnt == CW'(WAIT_T - 1)) begin
              tmo <= 1'b1;
              st  <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_RXS: if (tick) begin
          if (cnt == CW'(SAMP_T - 1)) begin
            cnt <= '0;
            sh  <= {ls2, sh[7:1]};
            if (bitn == 3'd7) begin
              rxd     <= 1'b1;
              rx_byte <= {ls2, sh[7:1]};
              st      <= S_IDLE;
            end else begin
              bitn <= bitn + 1'b1;
              st   <= S_RXW;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgm_regs.sv
module sgm_regs
  import sgm_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int SRST_CYC = 16,
  parameter logic [7:0] VER = 8'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              txd,
  input  logic              rxd,
  input  logic              tmo,
  input  logic [7:0]        rx_byte,
  output logic              start,
  output op_kind_e          kind,
  output logic [7:0]        tx_data_q,
  output logic              clken,
  output logic              ien,
  output logic              go,
  output logic [2:0]        flags,
  output logic              soft_clr,
  output logic              rst_done,
  output logic              irq
);
  localparam int SCW = $clog2(SRST_CYC + 1);

  logic [SCW-1:0] srst_cnt;
  logic           srst_wr;
  logic           brk, dir, mode, autoidle, launched;
  logic [7:0]     rx_data_q;
  logic           rd_flag;
  logic [2:0]     done_v;

  assign srst_wr  = wr_en && (int'(addr) == OFF_CFG) && wr_data[1];
  assign soft_clr = srst_wr || (srst_cnt != '0);
  assign rst_done = (srst_cnt == '0);
  assign start    = go && !launched && clken;
  assign kind     = brk ? OP_BRK : (dir ? OP_RX : OP_TX);
  assign rd_flag  = rd_en && (int'(addr) == OFF_FLAG);
  assign done_v   = {txd, rxd, tmo};

  always_ff @(posedge clk) begin
    if (rst) srst_cnt <= '0;
    else if (srst_cnt != '0) srst_cnt <= srst_cnt - 1'b1;
    else if (srst_wr) srst_cnt <= SCW'(SRST_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      ien       <= 1'b0;
      clken     <= 1'b0;
      go        <= 1'b0;
      brk       <= 1'b0;
      dir       <= 1'b0;
      mode      <= 1'b0;
      autoidle  <= 1'b0;
      launched  <= 1'b0;
      tx_data_q <= '0;
      rx_data_q <= '0;
      flags     <= '0;
      irq       <= 1'b0;
    end else begin
      irq   <= ien && (flags != '0);
      flags <= (flags & {3{~rd_flag}}) | done_v;
      if (start) launched <= 1'b1;
      if (rxd) rx_data_q <= rx_byte;
      if (done_v != '0) begin
        go       <= 1'b0;
        brk      <= 1'b0;
        launched <= 1'b0;
      end
      if (wr_en) begin
        case (int'(addr))
          OFF_CTRL: begin
            ien   <= wr_data[B_IEN];
            clken <= wr_data[B_CLKEN];
            mode  <= wr_data[B_MODE];
            if (!go) begin
              go  <= wr_data[B_GO];
              brk <= wr_data[B_BRK];
              dir <= wr_data[B_DIR];
            end
          end
          OFF_TXD: if (!go) tx_data_q <= wr_data;
          OFF_CFG: autoidle <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (int'(addr))
        OFF_VER:  rd_data <= VER;
        OFF_TXD:  rd_data <= tx_data_q;
        OFF_RXD:  rd_data <= rx_data_q;
        OFF_CTRL: rd_data <= {1'b0, ien, clken, go, 1'b0, brk, dir, mode};
        OFF_FLAG: rd_data <= {5'b0, flags};
        OFF_CFG:  rd_data <= {7'b0, autoidle};
        OFF_STAT: rd_data <= {7'b0, rst_done};
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sgm_master.sv
module sgm_master
  import sgm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int TICK_DIV  = 100,
  parameter int SLOT_T    = 190,
  parameter int ONE_T     = 32,
  parameter int ZERO_T    = 100,
  parameter int BRK_T     = 190,
  parameter int REC_T     = 40,
  parameter int SAMP_T    = 65,
  parameter int WAIT_T    = 500,
  parameter int SRST_CYC  = 16,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic              irq
);
  localparam logic [7:0] VER = {VER_MAJOR[3:0], VER_MINOR[3:0]};

  logic       tick, start, clken, ien, go, soft_clr, rst_done;
  logic       txd, rxd, tmo, drv;
  logic       phy_rst;
  op_kind_e   kind;
  logic [7:0] tx_data_q, rx_byte;
  logic [2:0] flags, done_vec;

  assign phy_rst        = rst || soft_clr;
  assign done_vec       = {txd, rxd, tmo};
  assign line_drive_low = drv && clken;

  sgm_regs #(.ADDR_W(ADDR_W), .SRST_CYC(SRST_CYC), .VER(VER)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .txd(txd), .rxd(rxd), .tmo(tmo),
    .rx_byte(rx_byte), .start(start), .kind(kind), .tx_data_q(tx_data_q),
    .clken(clken), .ien(ien), .go(go), .flags(flags), .soft_clr(soft_clr),
    .rst_done(rst_done), .irq(irq)
  );

  sgm_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(phy_rst), .en(clken), .tick(tick)
  );

  sgm_phy #(
    .SLOT_T(SLOT_T), .ONE_T(ONE_T), .ZERO_T(ZERO_T), .BRK_T(BRK_T),
    .REC_T(REC_T), .SAMP_T(SAMP_T), .WAIT_T(WAIT_T)
  ) u_phy (
    .clk(clk), .rst(phy_rst), .tick(tick), .start(start), .kind(kind),
    .tx_byte(tx_data_q), .line_in(line_in), .drv(drv), .txd(txd),
    .rxd(rxd), .tmo(tmo), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/sgm_checker.sv
module sgm_checker
  import sgm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wr_data,
  input logic              line_drive_low,
  input logic              irq,
  input logic              go,
  input logic              ien,
  input logic              soft_clr,
  input logic              rst_done,
  input logic [7:0]        tx_data_q,
  input logic [2:0]        flags,
  input logic [2:0]        done_vec
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !go |-> !line_drive_low); // R9

  AST_GO_HELD: assert property (@(posedge clk) disable iff (rst)
    (go && done_vec == 3'b000 && !soft_clr) |=> go); // R8

  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_vec)); // R2

  AST_DONE_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
    (done_vec != 3'b000) |-> go); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(addr) == OFF_FLAG && done_vec == 3'b000) |=> flags == 3'b000); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien)); // R7

  AST_TXD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (go && wr_en && int'(addr) == OFF_TXD) |=> $stable(tx_data_q)); // R8

  AST_SRST_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(addr) == OFF_CFG && wr_data[1]) |=> !rst_done); // R10
endmodule

bind sgm_master sgm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .line_drive_low(line_drive_low), .irq(irq), .go(go),
  .ien(ien), .soft_clr(soft_clr), .rst_done(rst_done), .tx_data_q(tx_data_q),
  .flags(flags), .done_vec(done_vec)
);

// File: tb/sgm_master_bench.sv
module sgm_master_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       line_drive_low, irq;
  logic       slave_low = 1'b0;
  logic       line;
  int         nchk = 0, nfail = 0;
  logic [8:0] exp_q[$];

  assign line = ~(line_drive_low | slave_low);

  always #5 clk = ~clk;

  sgm_master #(.TICK_DIV(1)) u_sgm_master (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .line_in(line),
    .line_drive_low(line_drive_low), .irq(irq)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 5'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 5'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 4000; i++) begin
      rd('h0C, c);
      if (!c[4]) break;
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] ctl);
    wr('h04, b);
    exp_q.push_back({1'b0, b});
    wr('h0C, ctl);
  endtask

  task automatic slave_tx(input logic [7:0] b);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      slave_low = 1'b1;
      repeat (b[i] ? 32 : 100) @(negedge clk);
      slave_low = 1'b0;
      repeat (b[i] ? 158 : 90) @(negedge clk);
    end
  endtask

  // scoreboard monitor: decodes low pulses on the line
  initial begin
    int w = 0, nb = 0;
    logic [7:0] acc = '0;
    logic [8:0] exp;
    forever begin
      @(negedge clk);
      if (line_drive_low) w++;
      else if (w > 0) begin
        if (w >= 150) begin
          nb = 0;
          exp = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
          check("R4 break pulse", 9'h100, exp);
        end else begin
          acc[nb] = (w < 66);
          nb++;
          if (nb == 8) begin
            nb = 0;
            exp = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
            check("R2 byte on line", {1'b0, acc}, exp);
          end
        end
        w = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       drove;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd('h0C, d); check("R1 ctrl", {1'b0, d}, 9'h000);
    rd('h10, d); check("R1 flags", {1'b0, d}, 9'h000);
    rd('h00, d); check("R1 version", {1'b0, d}, 9'h012);
    check("R1 irq/line", {7'b0, irq, line_drive_low}, 9'h000);
    rd('h18, d); check("R10 reset done", {1'b0, d}, 9'h001);

    wr('h0C, 8'h60);
    rd('h0C, d); check("R11 ctrl readback", {1'b0, d}, 9'h060);

    // R2 transmit with locked writes
    send(8'hA5, 8'h70);
    wr('h04, 8'h3C);
    wr('h0C, 8'h76);
    rd('h04, d); check("R8 txdata locked", {1'b0, d}, 9'h0A5);
    wait_idle();
    rd('h0C, d); check("R8 dir/brk unchanged, R2 start cleared", {1'b0, d}, 9'h060);
    repeat (2) @(negedge clk);
    check("R7 irq set", {8'b0, irq}, 9'h001);
    rd('h10, d); check("R2 sent flag", {1'b0, d}, 9'h004);
    rd('h10, d); check("R6 flags cleared by read", {1'b0, d}, 9'h000);
    repeat (2) @(negedge clk);
    check("R7 irq cleared", {8'b0, irq}, 9'h000);

    send(8'h01, 8'h70); wait_idle();
    send(8'hFE, 8'h70); wait_idle();
    rd('h10, d); check("R2 sent flag 2", {1'b0, d}, 9'h004);

    // R4 break
    exp_q.push_back(9'h100);
    wr('h0C, 8'h74);
    wait_idle();
    rd('h0C, d); check("R4 brk and start cleared", {1'b0, d}, 9'h060);
    rd('h10, d); check("R4 timeout flag", {1'b0, d}, 9'h001);

    // R3 receive
    fork
      slave_tx(8'h5A);
      wr('h0C, 8'h72);
    join
    wait_idle();
    rd('h10, d); check("R3 received flag", {1'b0, d}, 9'h002);
    rd('h08, d); check("R3 received byte", {1'b0, d}, 9'h05A);
    fork
      slave_tx(8'hC3);
      wr('h0C, 8'h72);
    join
    wait_idle();
    rd('h08, d); check("R3 received byte 2", {1'b0, d}, 9'h0C3);
    rd('h10, d);

    // R5 receive timeout
    wr('h0C, 8'h72);
    wait_idle();
    rd('h10, d); check("R5 timeout flag", {1'b0, d}, 9'h001);
    rd('h0C, d); check("R5 start cleared", {1'b0, d}, 9'h062);

    // R7 masked interrupt
    send(8'h81, 8'h30);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R7 irq masked", {8'b0, irq}, 9'h000);
    rd('h10, d); check("R7 flag still set", {1'b0, d}, 9'h004);

    // R9 clock enable off holds a pending start
    wr('h04, 8'h0F);
    wr('h0C, 8'h50);
    drove = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (line_drive_low) drove = 1'b1;
    end
    check("R9 no line activity", {8'b0, drove}, 9'h000);
    rd('h0C, d); check("R9 start pending", {1'b0, d}, 9'h050);
    exp_q.push_back(9'h00F);
    wr('h0C, 8'h60);
    wait_idle();
    rd('h10, d); check("R9 runs after enable", {1'b0, d}, 9'h004);

    // R10 soft reset
    wr('h14, 8'h01);
    rd('h14, d); check("R10 autoidle stored", {1'b0, d}, 9'h001);
    wr('h14, 8'h02);
    rd('h18, d); check("R10 reset busy", {1'b0, d}, 9'h000);
    repeat (20) @(negedge clk);
    rd('h18, d); check("R10 reset done again", {1'b0, d}, 9'h001);
    rd('h0C, d); check("R10 ctrl cleared", {1'b0, d}, 9'h000);
    rd('h14, d); check("R10 config cleared", {1'b0, d}, 9'h000);
    check("R11 rd_data holds", {1'b0, rd_data}, 9'h000);

    repeat (10) @(negedge clk);
    check("R2 scoreboard drained", 9'(exp_q.size()), 9'h000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule